// File: doc/BRIEF.md
# Data Access Address Translator and Rights Checker

This block sits in the load/store path. Each cycle a request may arrive with a virtual address, an access size, a write flag, four request qualifiers (physical, alternate-mode, page-table-entry load, no-fault), the current and alternate privilege modes, the low bit of the program counter and the instruction's opcode and register fields. The block sends the page number and address-space number to an external translation buffer. That buffer answers combinationally in the same cycle with a hit flag, a physical page number, per-mode read and write enables and two trap bits. One cycle later the block returns a physical address, a fault code and an uncacheable flag.

Checks run in a fixed priority: alignment first, then the physical bypass, then address-range validity, then the direct-mapped kernel window, then the lookup, and last the permission and trap bits. A final stage rejects physical addresses beyond the implemented width and decodes the uncacheable space. On most faults, three fault registers capture the faulting address, a packed status word and a formatted page-table address. Page-table-entry loads and no-fault requests never update them.

Top module: `dtrans_checker`

## Requirements
- R1: An access whose address has any nonzero bit below its size (`req_size` is log2 of the byte count, 0..3) returns fault code 1. Its status flags hold only the write flag. This check takes precedence over every other check.
- R2: Permissions are judged in the effective mode. It equals `cur_mode` when `pc_lsb` is 0. When `pc_lsb` is 1 it is kernel (mode 0), or `alt_mode` if `req_alt` is also set. Modes: 0 kernel, 1 executive, 2 supervisor, 3 user.
- R3: A non-physical address whose bits 63:47 are not all equal returns fault code 2 with status flags write, access-violation and bad-address.
- R4: A non-physical address whose bits 47:41 equal 0x7e is the direct kernel window. If `cur_mode` is not kernel it returns fault code 3 with flags write and access-violation, whatever `pc_lsb` is. In kernel mode the PA is the low 44 address bits. If bit 40 is set, bits 43:40 are forced to one; otherwise they are cleared.
- R5: A lookup miss returns fault code 5 for a page-table-entry load and fault code 4 otherwise. Status flags are miss and write.
- R6: On a mapped write whose write enable (bit index = effective mode) is clear, the result is fault code 2 with flags write and access-violation, plus fault-on-write if the entry has it. With the enable set, the entry's fault-on-write bit alone gives fault code 2 with flags write and fault-on-write.
- R7: On a mapped read whose read enable is clear, the result is fault code 3 with the access-violation flag, plus fault-on-read if set. With the enable set, the entry's fault-on-read bit alone gives fault code 2 with flag fault-on-read.
- R8: On a recorded fault, `flt_va` takes the address and `flt_form` takes `form_base` OR (address bits 47:13 shifted left by 3). `flt_stat` takes opcode in bits 16:11, register in bits 10:6 and flags in bits 5:0: write bit 0, access-violation bit 1, fault-on-read bit 2, fault-on-write bit 3, miss bit 4, bad-address bit 5.
- R9: Requests flagged as page-table-entry load or no-fault still return their fault code but leave all three fault registers unchanged.
- R10: A translated PA with any bit at or above bit 44 set returns fault code 6 (machine check) and leaves the fault registers unchanged.
- R11: A good PA with bit 43 set is reported uncacheable and returned with bits 42:35 cleared.
- R12: A physical request uses the address as the PA and skips the range, window, lookup and permission checks.
- R13: The result appears on the outputs exactly one cycle after `req_valid`. `rsp_pa` and `rsp_uncached` are zero whenever the fault code is nonzero. Fault code 0 means no fault. After reset the response and fault registers are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_va | input | 64 | Virtual address |
| req_size | input | 2 | log2 of access size in bytes |
| req_write | input | 1 | Store when 1 |
| req_phys | input | 1 | Address is already physical |
| req_alt | input | 1 | Use alternate mode when pc_lsb is set |
| req_vpte | input | 1 | Page-table-entry load |
| req_nofault | input | 1 | Do not record fault registers |
| cur_mode | input | 2 | Current privilege mode |
| alt_mode | input | 2 | Alternate privilege mode |
| pc_lsb | input | 1 | Bit 0 of the program counter |
| asn | input | 8 | Address-space number |
| inst_opcode | input | 6 | Opcode of the issuing instruction |
| inst_ra | input | 5 | Register field of the issuing instruction |
| form_base | input | 64 | Base for the formatted fault address |
| lkp_vpn | output | 35 | Page number sent to the translation buffer |
| lkp_asn | output | 8 | Address-space number sent to the translation buffer |
| tlb_hit | input | 1 | Lookup hit |
| tlb_ppn | input | 32 | Physical page number |
| tlb_rd_en | input | 4 | Read enable per mode |
| tlb_wr_en | input | 4 | Write enable per mode |
| tlb_fonr | input | 1 | Fault-on-read trap bit |
| tlb_fonw | input | 1 | Fault-on-write trap bit |
| rsp_valid | output | 1 | Result present |
| rsp_fault | output | 3 | Fault code |
| rsp_pa | output | 64 | Physical address |
| rsp_uncached | output | 1 | Access is uncacheable |
| flt_va | output | 64 | Recorded faulting address |
| flt_stat | output | 17 | Recorded status word |
| flt_form | output | 64 | Recorded formatted address |

## Verification
The permission denial and the trap bit of the same entry can trigger on the same access. The status word must then carry both reasons, while the fault code follows the denial. The bench provokes this with writes that have a clear write enable and a set fault-on-write bit, and with the matching read case. It judges the combined flags against a model built from R6 and R7. A second collision is the recording suppression meeting a real fault. A no-fault or page-table-entry request with a denied access must still return its code and leave the three fault registers at the values the previous recorded fault left.

// File: rtl/dxc_pkg.sv
// Shared types for the data address translator.
// Assumes fault codes and status flag positions are fixed across the chip.
package dxc_pkg;
    typedef enum logic [2:0] {
        FLT_NONE    = 3'd0,
        FLT_ALIGN   = 3'd1,
        FLT_PAGE    = 3'd2,
        FLT_ACV     = 3'd3,
        FLT_MISS    = 3'd4,
        FLT_MISS_PT = 3'd5,
        FLT_MCHK    = 3'd6
    } fault_e;

    localparam int unsigned FLAG_W   = 6;
    localparam int unsigned ST_WR    = 0;
    localparam int unsigned ST_ACV   = 1;
    localparam int unsigned ST_FONR  = 2;
    localparam int unsigned ST_FONW  = 3;
    localparam int unsigned ST_MISS  = 4;
    localparam int unsigned ST_BADVA = 5;

    localparam logic [1:0] MODE_KERNEL = 2'd0;
endpackage

// File: rtl/dxc_mode_sel.sv
// Effective privilege mode selection.
// Assumes pc_lsb marks privileged code; the alternate mode applies only then.
module dxc_mode_sel (
    input  logic [1:0] cur_mode,
    input  logic [1:0] alt_mode,
    input  logic       pc_lsb,
    input  logic       use_alt,
    output logic [1:0] eff_mode
);
    import dxc_pkg::*;

    // Pick the mode used for permission lookup.
    always_comb begin
        if (!pc_lsb)
            eff_mode = cur_mode;
        else if (use_alt)
            eff_mode = alt_mode;
        else
            eff_mode = MODE_KERNEL;
    end
endmodule

// File: rtl/dxc_addr_class.sv
// Classifies a virtual address: alignment, range validity, kernel window,
// and the window's direct physical mapping with the high-bit extension rule.
// Assumes VA_IMPL-bit sign-extended virtual addresses.
module dxc_addr_class #(
    parameter int unsigned VA_W     = 64,
    parameter int unsigned VA_IMPL  = 48,
    parameter int unsigned PA_IMPL  = 44,
    parameter int unsigned SIZE_W   = 2,
    parameter int unsigned WIN_HI   = 47,
    parameter int unsigned WIN_LO   = 41,
    parameter logic [WIN_HI-WIN_LO:0] WIN_TAG = 7'h7e,
    parameter int unsigned EXT_BIT  = 40
) (
    input  logic [VA_W-1:0]   va,
    input  logic [SIZE_W-1:0] size_lg,
    output logic              misaligned,
    output logic              va_bad,
    output logic              in_window,
    output logic [VA_W-1:0]   win_pa
);
    localparam int unsigned OFS_W = (1 << SIZE_W) - 1;
    localparam int unsigned HI_W  = VA_W - VA_IMPL + 1;

    logic [OFS_W-1:0] low_mask;
    logic [HI_W-1:0]  hi_bits;
    logic [VA_W-1:0]  trunc;

    // Build the mask of address bits that must be zero for this size.
    generate
        for (genvar i = 0; i < OFS_W; i++) begin : g_mask
            assign low_mask[i] = (32'(i) < 32'(size_lg));
        end
    endgenerate

    // Alignment, range and window decode.
    always_comb begin
        misaligned = |(va[OFS_W-1:0] & low_mask);
        hi_bits    = va[VA_W-1:VA_IMPL-1];
        va_bad     = !((&hi_bits) || !(|hi_bits));
        in_window  = (va[WIN_HI:WIN_LO] == WIN_TAG);
    end

    // Direct mapping of the kernel window with bit EXT_BIT extended upward.
    always_comb begin
        trunc = '0;
        trunc[PA_IMPL-1:0] = va[PA_IMPL-1:0];
        win_pa = trunc;
        for (int b = EXT_BIT; b < PA_IMPL; b++)
            win_pa[b] = va[EXT_BIT];
    end
endmodule

// File: rtl/dxc_perm_check.sv
// Priority chain of translation checks and the pre-check physical address.
// Assumes the lookup result is valid in the same cycle as the request.
module dxc_perm_check #(
    parameter int unsigned VA_W       = 64,
    parameter int unsigned PPN_W      = 32,
    parameter int unsigned PAGE_SHIFT = 13
) (
    input  logic [VA_W-1:0]  va,
    input  logic             is_write,
    input  logic             is_phys,
    input  logic             is_vpte,
    input  logic             misaligned,
    input  logic             va_bad,
    input  logic             in_window,
    input  logic [VA_W-1:0]  win_pa,
    input  logic [1:0]       cur_mode,
    input  logic [1:0]       eff_mode,
    input  logic             tlb_hit,
    input  logic [PPN_W-1:0] tlb_ppn,
    input  logic [3:0]       tlb_rd_en,
    input  logic [3:0]       tlb_wr_en,
    input  logic             tlb_fonr,
    input  logic             tlb_fonw,
    output dxc_pkg::fault_e  fault,
    output logic [dxc_pkg::FLAG_W-1:0] flags,
    output logic [VA_W-1:0]  pa_pre
);
    import dxc_pkg::*;

    logic [VA_W-1:0] mapped_pa;

    // Page number and untouched page offset form the mapped address.
    always_comb begin
        mapped_pa = (VA_W'(tlb_ppn) << PAGE_SHIFT) | VA_W'(va[PAGE_SHIFT-1:0]);
    end

    // Evaluate checks in fixed priority order.
    always_comb begin
        fault  = FLT_NONE;
        flags  = '0;
        pa_pre = '0;
        if (misaligned) begin
            fault         = FLT_ALIGN;
            flags[ST_WR]  = is_write;
        end else if (is_phys) begin
            pa_pre = va;
        end else if (va_bad) begin
            fault           = FLT_PAGE;
            flags[ST_WR]    = is_write;
            flags[ST_ACV]   = 1'b1;
            flags[ST_BADVA] = 1'b1;
        end else if (in_window) begin
            if (cur_mode != MODE_KERNEL) begin
                fault         = FLT_ACV;
                flags[ST_WR]  = is_write;
                flags[ST_ACV] = 1'b1;
            end else begin
                pa_pre = win_pa;
            end
        end else if (!tlb_hit) begin
            fault          = is_vpte ? FLT_MISS_PT : FLT_MISS;
            flags[ST_WR]   = is_write;
            flags[ST_MISS] = 1'b1;
        end else begin
            pa_pre = mapped_pa;
            if (is_write) begin
                if (!tlb_wr_en[eff_mode]) begin
                    fault          = FLT_PAGE;
                    flags[ST_WR]   = 1'b1;
                    flags[ST_ACV]  = 1'b1;
                    flags[ST_FONW] = tlb_fonw;
                end else if (tlb_fonw) begin
                    fault          = FLT_PAGE;
                    flags[ST_WR]   = 1'b1;
                    flags[ST_FONW] = 1'b1;
                end
            end else begin
                if (!tlb_rd_en[eff_mode]) begin
                    fault          = FLT_ACV;
                    flags[ST_ACV]  = 1'b1;
                    flags[ST_FONR] = tlb_fonr;
                end else if (tlb_fonr) begin
                    fault          = FLT_PAGE;
                    flags[ST_FONR] = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/dxc_pa_finish.sv
// Final physical address stage: implemented-width check and uncacheable
// space decode with clearing of the space-select bits.
// Assumes the check is applied only when no earlier fault was found.
module dxc_pa_finish #(
    parameter int unsigned VA_W    = 64,
    parameter int unsigned PA_IMPL = 44,
    parameter int unsigned UNC_BIT = 43,
    parameter int unsigned CLR_HI  = 42,
    parameter int unsigned CLR_LO  = 35
) (
    input  logic [VA_W-1:0] pa_pre,
    input  logic            check_en,
    output logic            mchk,
    output logic            uncached,
    output logic [VA_W-1:0] pa_out
);
    // Reject addresses beyond the implemented width, then decode space.
    always_comb begin
        mchk     = check_en && (|pa_pre[VA_W-1:PA_IMPL]);
        uncached = 1'b0;
        pa_out   = pa_pre;
        if (check_en && !mchk && pa_pre[UNC_BIT]) begin
            uncached = 1'b1;
            pa_out[CLR_HI:CLR_LO] = '0;
        end
    end
endmodule

// File: rtl/dtrans_checker.sv
// Data address translator and rights checker, one-cycle registered result.
// Drives the lookup key out, combines the check stages, and records fault
// registers unless the request is a page-table-entry load or no-fault.
module dtrans_checker #(
    parameter int unsigned VA_W       = 64,
    parameter int unsigned VA_IMPL    = 48,
    parameter int unsigned PA_IMPL    = 44,
    parameter int unsigned PPN_W      = 32,
    parameter int unsigned PAGE_SHIFT = 13,
    parameter int unsigned ASN_W      = 8,
    parameter int unsigned SIZE_W     = 2
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            req_valid,
    input  logic [VA_W-1:0]                 req_va,
    input  logic [SIZE_W-1:0]               req_size,
    input  logic                            req_write,
    input  logic                            req_phys,
    input  logic                            req_alt,
    input  logic                            req_vpte,
    input  logic                            req_nofault,
    input  logic [1:0]                      cur_mode,
    input  logic [1:0]                      alt_mode,
    input  logic                            pc_lsb,
    input  logic [ASN_W-1:0]                asn,
    input  logic [5:0]                      inst_opcode,
    input  logic [4:0]                      inst_ra,
    input  logic [VA_W-1:0]                 form_base,
    output logic [VA_IMPL-PAGE_SHIFT-1:0]   lkp_vpn,
    output logic [ASN_W-1:0]                lkp_asn,
    input  logic                            tlb_hit,
    input  logic [PPN_W-1:0]                tlb_ppn,
    input  logic [3:0]                      tlb_rd_en,
    input  logic [3:0]                      tlb_wr_en,
    input  logic                            tlb_fonr,
    input  logic                            tlb_fonw,
    output logic                            rsp_valid,
    output logic [2:0]                      rsp_fault,
    output logic [VA_W-1:0]                 rsp_pa,
    output logic                            rsp_uncached,
    output logic [VA_W-1:0]                 flt_va,
    output logic [16:0]                     flt_stat,
    output logic [VA_W-1:0]                 flt_form
);
    import dxc_pkg::*;

    localparam int unsigned VPN_W   = VA_IMPL - PAGE_SHIFT;
    localparam int unsigned UNC_BIT = PA_IMPL - 1;

    logic                eff_mode_ok;
    logic [1:0]          eff_mode;
    logic                misaligned, va_bad, in_window;
    logic [VA_W-1:0]     win_pa, pa_pre, pa_out;
    fault_e              pre_fault, fin_fault;
    logic [FLAG_W-1:0]   flags;
    logic                mchk, uncached, record;

    // Lookup key goes straight to the translation buffer.
    always_comb begin
        lkp_vpn = req_va[VA_IMPL-1:PAGE_SHIFT];
        lkp_asn = asn;
    end

    dxc_mode_sel u_mode (
        .cur_mode (cur_mode),
        .alt_mode (alt_mode),
        .pc_lsb   (pc_lsb),
        .use_alt  (req_alt),
        .eff_mode (eff_mode)
    );

    dxc_addr_class #(
        .VA_W(VA_W), .VA_IMPL(VA_IMPL), .PA_IMPL(PA_IMPL), .SIZE_W(SIZE_W)
    ) u_class (
        .va         (req_va),
        .size_lg    (req_size),
        .misaligned (misaligned),
        .va_bad     (va_bad),
        .in_window  (in_window),
        .win_pa     (win_pa)
    );

    dxc_perm_check #(
        .VA_W(VA_W), .PPN_W(PPN_W), .PAGE_SHIFT(PAGE_SHIFT)
    ) u_perm (
        .va         (req_va),
        .is_write   (req_write),
        .is_phys    (req_phys),
        .is_vpte    (req_vpte),
        .misaligned (misaligned),
        .va_bad     (va_bad),
        .in_window  (in_window),
        .win_pa     (win_pa),
        .cur_mode   (cur_mode),
        .eff_mode   (eff_mode),
        .tlb_hit    (tlb_hit),
        .tlb_ppn    (tlb_ppn),
        .tlb_rd_en  (tlb_rd_en),
        .tlb_wr_en  (tlb_wr_en),
        .tlb_fonr   (tlb_fonr),
        .tlb_fonw   (tlb_fonw),
        .fault      (pre_fault),
        .flags      (flags),
        .pa_pre     (pa_pre)
    );

    dxc_pa_finish #(
        .VA_W(VA_W), .PA_IMPL(PA_IMPL), .UNC_BIT(UNC_BIT),
        .CLR_HI(UNC_BIT-1), .CLR_LO(UNC_BIT-8)
    ) u_fin (
        .pa_pre   (pa_pre),
        .check_en (eff_mode_ok),
        .mchk     (mchk),
        .uncached (uncached),
        .pa_out   (pa_out)
    );

    // Merge the machine check into the final fault and decide recording.
    always_comb begin
        eff_mode_ok = (pre_fault == FLT_NONE);
        fin_fault   = mchk ? FLT_MCHK : pre_fault;
        record      = req_valid && (pre_fault != FLT_NONE)
                      && !req_vpte && !req_nofault;
    end

    // Response register: one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid    <= 1'b0;
            rsp_fault    <= 3'd0;
            rsp_pa       <= '0;
            rsp_uncached <= 1'b0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                rsp_fault    <= fin_fault;
                rsp_pa       <= (fin_fault == FLT_NONE) ? pa_out : '0;
                rsp_uncached <= (fin_fault == FLT_NONE) && uncached;
            end
        end
    end

    // Fault registers: capture address, status word and formatted address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flt_va   <= '0;
            flt_stat <= '0;
            flt_form <= '0;
        end else if (record) begin
            flt_va   <= req_va;
            flt_stat <= {inst_opcode, inst_ra, flags};
            flt_form <= form_base | (VA_W'(req_va[VA_IMPL-1:PAGE_SHIFT]) << 3);
        end
    end

    AST_ALIGN_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && misaligned |=> rsp_fault == 3'(FLT_ALIGN)); // R1

    AST_WINDOW_PRIV: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !misaligned && !req_phys && !va_bad && in_window
        && cur_mode != MODE_KERNEL |=> rsp_fault == 3'(FLT_ACV)); // R4

    AST_NO_RECORD: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && (req_vpte || req_nofault)
        |=> $stable(flt_va) && $stable(flt_stat) && $stable(flt_form)); // R9

    AST_MCHK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && mchk |=> $stable(flt_stat) && rsp_pa == '0); // R10

    AST_UNC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_uncached
        |-> rsp_pa[UNC_BIT] && rsp_pa[UNC_BIT-1:UNC_BIT-8] == '0); // R11

    AST_FAULT_NO_PA: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_fault != 3'd0 |-> rsp_pa == '0 && !rsp_uncached); // R13
endmodule

// File: tb/dtrans_checker_tb.sv
`timescale 1ns/1ps
module dtrans_checker_tb_top;
    typedef struct {
        logic [63:0] va;   logic [1:0] sz;
        bit wr, ph, alt, vpte, nof;
        logic [1:0] cur, altm; bit pcl;
        logic [5:0] opc; logic [4:0] ra;
        bit hit; logic [31:0] ppn; logic [3:0] rden, wren; bit fonr, fonw;
    } req_t;
    typedef struct {
        logic [2:0] f; logic [63:0] pa; bit unc;
        logic [63:0] fva; logic [16:0] fst; logic [63:0] ffm; string tag;
    } exp_t;

    localparam logic [63:0] BASE = 64'h0000_7A00_0000_0000;

    logic clk = 1'b0, rst_n = 1'b0;
    always #4 clk = ~clk;

    logic        req_valid = 0, req_write = 0, req_phys = 0, req_alt = 0;
    logic        req_vpte = 0, req_nofault = 0, pc_lsb = 0;
    logic [63:0] req_va = 0;
    logic [1:0]  req_size = 0, cur_mode = 0, alt_mode = 0;
    logic [7:0]  asn = 8'h3c;
    logic [5:0]  inst_opcode = 0;
    logic [4:0]  inst_ra = 0;
    logic [34:0] lkp_vpn;
    logic [7:0]  lkp_asn;
    logic        tlb_hit = 0, tlb_fonr = 0, tlb_fonw = 0;
    logic [31:0] tlb_ppn = 0;
    logic [3:0]  tlb_rd_en = 0, tlb_wr_en = 0;
    logic        rsp_valid, rsp_uncached;
    logic [2:0]  rsp_fault;
    logic [63:0] rsp_pa, flt_va, flt_form;
    logic [16:0] flt_stat;

    int n_run = 0, n_fail = 0;
    bit done = 0;
    exp_t q[$];
    logic [63:0] s_va = 0, s_fm = 0;
    logic [16:0] s_st = 0;

    dtrans_checker dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_va(req_va),
        .req_size(req_size), .req_write(req_write), .req_phys(req_phys),
        .req_alt(req_alt), .req_vpte(req_vpte), .req_nofault(req_nofault),
        .cur_mode(cur_mode), .alt_mode(alt_mode), .pc_lsb(pc_lsb), .asn(asn),
        .inst_opcode(inst_opcode), .inst_ra(inst_ra), .form_base(BASE),
        .lkp_vpn(lkp_vpn), .lkp_asn(lkp_asn), .tlb_hit(tlb_hit),
        .tlb_ppn(tlb_ppn), .tlb_rd_en(tlb_rd_en), .tlb_wr_en(tlb_wr_en),
        .tlb_fonr(tlb_fonr), .tlb_fonw(tlb_fonw), .rsp_valid(rsp_valid),
        .rsp_fault(rsp_fault), .rsp_pa(rsp_pa), .rsp_uncached(rsp_uncached),
        .flt_va(flt_va), .flt_stat(flt_stat), .flt_form(flt_form)
    );

    task automatic chk(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Reference model written from the requirements.
    function automatic exp_t model(req_t r, string tag);
        exp_t e; logic [5:0] fl; logic [1:0] eff; logic [63:0] m; logic [16:0] hi;
        e.f = 0; e.pa = 0; e.unc = 0; e.tag = tag; fl = 0;
        eff = r.pcl ? (r.alt ? r.altm : 2'd0) : r.cur;
        m = (64'd1 << r.sz) - 1;
        hi = r.va[63:47];
        if ((r.va & m) != 0) begin e.f = 1; fl[0] = r.wr; end
        else if (r.ph) e.pa = r.va;
        else if (!(hi == 0 || hi == '1)) begin e.f = 2; fl = {1'b1, 3'b0, 1'b1, r.wr}; end
        else if (r.va[47:41] == 7'h7e) begin
            if (r.cur != 0) begin e.f = 3; fl[1] = 1; fl[0] = r.wr; end
            else begin
                e.pa = {20'd0, r.va[43:0]};
                e.pa[43:40] = r.va[40] ? 4'hf : 4'h0;
            end
        end else if (!r.hit) begin e.f = r.vpte ? 5 : 4; fl[4] = 1; fl[0] = r.wr; end
        else begin
            e.pa = ({32'd0, r.ppn} << 13) | {51'd0, r.va[12:0]};
            if (r.wr) begin
                if (!r.wren[eff]) begin e.f = 2; fl[0] = 1; fl[1] = 1; fl[3] = r.fonw; end
                else if (r.fonw) begin e.f = 2; fl[0] = 1; fl[3] = 1; end
            end else begin
                if (!r.rden[eff]) begin e.f = 3; fl[1] = 1; fl[2] = r.fonr; end
                else if (r.fonr) begin e.f = 2; fl[2] = 1; end
            end
        end
        if (e.f != 0 && !r.vpte && !r.nof) begin
            s_va = r.va; s_st = {r.opc, r.ra, fl};
            s_fm = BASE | ({29'd0, r.va[47:13]} << 3);
        end
        if (e.f == 0) begin
            if (e.pa[63:44] != 0) e.f = 6;
            else if (e.pa[43]) begin e.unc = 1; e.pa[42:35] = 0; end
        end
        if (e.f != 0) begin e.pa = 0; e.unc = 0; end
        e.fva = s_va; e.fst = s_st; e.ffm = s_fm;
        return e;
    endfunction

    // Driver: apply one request at a negedge and queue its expectation.
    task automatic send(req_t r, string tag);
        req_valid = 1; req_va = r.va; req_size = r.sz; req_write = r.wr;
        req_phys = r.ph; req_alt = r.alt; req_vpte = r.vpte; req_nofault = r.nof;
        cur_mode = r.cur; alt_mode = r.altm; pc_lsb = r.pcl;
        inst_opcode = r.opc; inst_ra = r.ra; tlb_hit = r.hit; tlb_ppn = r.ppn;
        tlb_rd_en = r.rden; tlb_wr_en = r.wren; tlb_fonr = r.fonr; tlb_fonw = r.fonw;
        q.push_back(model(r, tag));
        @(negedge clk);
    endtask

    // Monitor: compare each result one cycle after its request.
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (q.size() == 0) chk(0, "R13", "unexpected response", 1, 0);
            else begin
                exp_t e; e = q.pop_front();
                chk(rsp_fault == e.f, e.tag, "fault", 64'(rsp_fault), 64'(e.f));
                chk(rsp_pa == e.pa, e.tag, "pa", rsp_pa, e.pa);
                chk(rsp_uncached == e.unc, e.tag, "uncached", 64'(rsp_uncached), 64'(e.unc));
                chk(flt_va == e.fva, e.tag, "flt_va", flt_va, e.fva);
                chk(flt_stat == e.fst, e.tag, "flt_stat", 64'(flt_stat), 64'(e.fst));
                chk(flt_form == e.ffm, e.tag, "flt_form", flt_form, e.ffm);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        req_t b, r;
        b = '{va: 64'h0000_0012_3456_7000, sz: 2'd3, wr: 0, ph: 0, alt: 0, vpte: 0,
              nof: 0, cur: 2'd3, altm: 2'd0, pcl: 0, opc: 6'h29, ra: 5'd7, hit: 1,
              ppn: 32'h0000_0456, rden: 4'hf, wren: 4'hf, fonr: 0, fonw: 0};
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(rsp_valid == 0, "R13", "reset rsp_valid", 64'(rsp_valid), 0);
        chk(flt_stat == 0, "R13", "reset flt_stat", 64'(flt_stat), 0);
        chk(flt_va == 0, "R13", "reset flt_va", flt_va, 0);

        r = b; r.ph = 1; r.va = 64'h0000_0001_2345_6788; r.rden = 0; send(r, "R12 physical bypass");
        r = b; r.ph = 1; r.va = 64'h0004_0000_0000_0000; send(r, "R10 physical beyond width");
        r = b; r.ph = 1; r.va = 64'h0000_0FF0_0000_1230; send(r, "R11 uncached physical");
        r = b; r.va = 64'h0000_0000_0000_1002; r.sz = 2; r.wr = 1; r.opc = 6'h2c; r.ra = 5'd3;
        send(r, "R1 misaligned write");
        r = b; r.va = 64'h0001_0000_0000_0001; r.sz = 1; r.opc = 6'h28; send(r, "R1 misaligned beats bad VA");
        r = b; r.va = 64'h0000_0000_0000_0004; r.sz = 2; send(r, "R1 aligned longword");
        r = b; r.va = 64'h0001_0000_0000_0000; r.opc = 6'h23; r.ra = 5'd9; send(r, "R3 bad VA read");
        r = b; r.va = 64'h8000_0000_0000_0000; r.wr = 1; send(r, "R3 bad VA write");
        r = b; r.va = 64'hFFFF_FC00_1234_5678; r.sz = 0; r.cur = 2; send(r, "R4 window outside kernel");
        r = b; r.va = 64'hFFFF_FC00_1234_5678; r.sz = 0; r.cur = 1; r.pcl = 1; r.wr = 1;
        send(r, "R4 window judged on current mode");
        r = b; r.va = 64'hFFFF_FC00_1234_5678; r.sz = 0; r.cur = 0; send(r, "R4 window kernel low");
        r = b; r.va = 64'hFFFF_FD00_0000_1008; r.cur = 0; send(r, "R4 R11 window kernel extended");
        r = b; r.hit = 0; r.wr = 1; r.opc = 6'h2d; send(r, "R5 ordinary miss");
        r = b; r.hit = 0; r.vpte = 1; r.va = 64'h0000_0000_4000_2000; send(r, "R5 R9 page-table miss");
        r = b; r.rden = 4'b1000; send(r, "R7 mapped read allowed");
        r = b; r.wr = 1; r.wren = 4'b0111; r.fonw = 1; r.va = 64'h0000_0000_0000_3ff8;
        send(r, "R6 write denied with trap");
        r = b; r.wr = 1; r.wren = 4'b0111; send(r, "R6 write denied");
        r = b; r.wr = 1; r.fonw = 1; r.ra = 5'd31; send(r, "R6 fault-on-write only");
        r = b; r.rden = 4'b0001; r.fonr = 1; send(r, "R7 read denied with trap");
        r = b; r.fonr = 1; r.opc = 6'h3f; send(r, "R7 fault-on-read only");
        r = b; r.rden = 4'b0001; r.pcl = 1; send(r, "R2 odd pc gives kernel");
        r = b; r.rden = 4'b0100; r.pcl = 1; r.alt = 1; r.altm = 2; send(r, "R2 alternate mode allowed");
        r = b; r.rden = 4'b0001; r.pcl = 1; r.alt = 1; r.altm = 2; send(r, "R2 alternate mode denied");
        r = b; r.rden = 4'b0001; r.alt = 1; r.altm = 0; send(r, "R2 alternate ignored on even pc");
        r = b; r.nof = 1; r.rden = 0; r.va = 64'h0000_0000_7777_0000; send(r, "R9 no-fault denied read");
        r = b; r.ppn = 32'h8000_0001; send(r, "R10 mapped beyond width");
        r = b; r.ppn = 32'h4000_0005; r.va = 64'h0000_0000_0000_0abc; r.sz = 2; send(r, "R11 mapped uncached");
        r = b; r.va = 64'h0000_0055_0000_0000; r.opc = 6'h11; r.ra = 5'd17; r.hit = 0;
        send(r, "R8 status packing");
        req_valid = 0;
        repeat (4) @(negedge clk);
        chk(q.size() == 0, "R13", "responses drained", 64'(q.size()), 0);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule